// File: doc/BRIEF.md
# Memory Access Region Guard with Fault Capture

This block sits between a processor's address generation and its translation buffer. Every cycle it takes one 32-bit virtual address, the kind of access (data read, data write or instruction fetch) and the current privilege level. It decides whether the address skips translation, goes through the translation buffer, or is refused outright. The translation buffer lives outside the block. It returns, in the same cycle, a hit flag, a 20-bit physical page number and three permission bits. From these the block forms a physical address or names a fault cause, all without a register stage.

When a valid access faults, three control registers are updated on the next clock edge. These are the faulting-address register, the page-table-entry address register and a one-bit data/instruction side flag. The page-table-entry address register has a software-loaded base field that faults never overwrite. A second, read-only port translates a debug address using its own lookup inputs. This port changes no register.

Top module: `mmu_region_guard`

## Requirements
- R1: After reset the faulting-address register, the page-table-entry address register and the side flag all read zero.
- R2: With `mmu_on` low, every valid access succeeds with `acc_paddr` equal to `acc_vaddr` and cause 0, whatever the lookup inputs say.
- R3: A supervisor access at 0xC0000000 or above succeeds with `acc_paddr` equal to `acc_vaddr`, even when the lookup misses or denies.
- R4: A translated access (supervisor below 0xC0000000, or user below 0x80000000) that hits and holds the needed permission succeeds with `acc_paddr` = {`lk_ppage`, `acc_vaddr[11:0]`}.
- R5: A translated access whose lookup misses faults with cause 1.
- R6: A translated hit lacking permission faults. Kind 0 (read) needs `lk_perm[0]` and gives cause 2. Kind 1 (write) needs `lk_perm[1]` and gives cause 3. Kind 2 or 3 (fetch) needs `lk_perm[2]` and gives cause 4.
- R7: A user access at 0x80000000 or above (with `mmu_on` high) faults with cause 5 and ignores the lookup. On the next edge it loads the faulting-address register but leaves the page-table-entry address register and the side flag unchanged.
- R8: On a cause 1 to 4 fault, the side flag becomes 0 for a fetch and 1 for a read or write.
- R9: On any fault the faulting-address register takes the full address. On a cause 1 to 4 fault the page-table-entry address register takes `acc_vaddr[31:12]` in bits [21:2] and zero in bits [1:0], and keeps bits [31:22].
- R10: `acc_ok` and `acc_fault` are never both high, both are low while `acc_valid` is low, and a cycle without a valid fault changes no register except through R11.
- R11: `pt_base_load` writes `pt_base_val` into bits [31:22] of the page-table-entry address register on the next edge. Other bits are unchanged unless a fault in the same cycle rewrites them.
- R12: The debug port returns {`dbg_ppage`, 12'b0} on a hit and all ones on a miss when `mmu_on` is high and `dbg_vaddr` is below 0xC0000000. Otherwise it returns `dbg_vaddr` with bits [11:0] cleared. It never modifies any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mmu_on | input | 1 | Translation hardware present and enabled |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_vaddr | input | 32 | Virtual address of the access |
| acc_kind | input | 2 | 0 read, 1 write, 2 or 3 fetch |
| acc_super | input | 1 | Access made in supervisor mode |
| lk_hit | input | 1 | Lookup found a matching entry |
| lk_ppage | input | 20 | Physical page number from the lookup |
| lk_perm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| pt_base_load | input | 1 | Load the page-table base field |
| pt_base_val | input | 10 | New page-table base value |
| acc_ok | output | 1 | Valid access succeeded |
| acc_fault | output | 1 | Valid access faulted |
| acc_cause | output | 3 | Fault cause, 0 when no fault |
| acc_paddr | output | 32 | Physical address, 0 on fault |
| rec_badaddr | output | 32 | Faulting-address register |
| rec_pteaddr | output | 32 | Page-table-entry address register |
| rec_dside | output | 1 | Side flag of the last translation fault |
| dbg_vaddr | input | 32 | Debug translate address |
| dbg_hit | input | 1 | Debug lookup hit |
| dbg_ppage | input | 20 | Debug lookup physical page |
| dbg_paddr | output | 32 | Debug translate result |

## Verification
A wrong region decision or permission select shows up in the same cycle as the access, as a wrong cause or a wrong physical address on the combinational outputs. A wrong register update stays hidden until the edge that follows a faulting access. One cycle later, a wrong VPN placement, a clobbered base field or an inverted side flag can be read directly from the record outputs. Region boundaries just under and at 0x80000000 and 0xC0000000 are driven on purpose, because an off-by-one decode only shows there. Idle and user-region faults are checked to prove that the registers which should hold do hold.

// File: rtl/mmu_guard_pkg.sv
package mmu_guard_pkg;

    typedef enum logic [1:0] {
        RGN_BYPASS    = 2'd0,
        RGN_TRANSLATE = 2'd1,
        RGN_DENIED    = 2'd2
    } region_e;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_MISS   = 3'd1,
        CAUSE_PERM_R = 3'd2,
        CAUSE_PERM_W = 3'd3,
        CAUSE_PERM_X = 3'd4,
        CAUSE_SUPER  = 3'd5
    } cause_e;

    localparam int KIND_W = 2;
    localparam int PERM_W = 3;

endpackage

// File: rtl/mmu_region_decode.sv
module mmu_region_decode
    import mmu_guard_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic            super_mode,
    input  logic            mmu_on,
    output region_e         region
);

    logic top_bit;
    logic top_two;

    always_comb begin
        top_bit = vaddr[VA_W-1];
        top_two = vaddr[VA_W-1] & vaddr[VA_W-2];
        if (!mmu_on) begin
            region = RGN_BYPASS;
        end else if (super_mode) begin
            region = top_two ? RGN_BYPASS : RGN_TRANSLATE;
        end else begin
            region = top_bit ? RGN_DENIED : RGN_TRANSLATE;
        end
    end

endmodule

// File: rtl/mmu_perm_resolve.sv
module mmu_perm_resolve
    import mmu_guard_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12
) (
    input  region_e               region,
    input  logic [VA_W-1:0]       vaddr,
    input  logic [KIND_W-1:0]     kind,
    input  logic                  hit,
    input  logic [VA_W-PAGE_BITS-1:0] ppage,
    input  logic [PERM_W-1:0]     perm,
    output cause_e                cause,
    output logic [VA_W-1:0]       paddr
);

    localparam int PPN_W = VA_W - PAGE_BITS;

    logic   allowed;
    cause_e deny_cause;

    always_comb begin
        if (kind[1]) begin
            allowed    = perm[2];
            deny_cause = CAUSE_PERM_X;
        end else if (kind[0]) begin
            allowed    = perm[1];
            deny_cause = CAUSE_PERM_W;
        end else begin
            allowed    = perm[0];
            deny_cause = CAUSE_PERM_R;
        end

        cause = CAUSE_NONE;
        paddr = '0;
        unique case (region)
            RGN_BYPASS: begin
                paddr = vaddr;
            end
            RGN_DENIED: begin
                cause = CAUSE_SUPER;
            end
            RGN_TRANSLATE: begin
                if (!hit) begin
                    cause = CAUSE_MISS;
                end else if (!allowed) begin
                    cause = deny_cause;
                end else begin
                    paddr = {ppage[PPN_W-1:0], vaddr[PAGE_BITS-1:0]};
                end
            end
            default: begin
                cause = CAUSE_NONE;
            end
        endcase
    end

endmodule

// File: rtl/mmu_fault_regs.sv
module mmu_fault_regs #(
    parameter int VA_W       = 32,
    parameter int PAGE_BITS  = 12,
    parameter int PTE_LSB    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rec_any,
    input  logic                rec_tlb,
    input  logic [VA_W-1:0]     vaddr,
    input  logic                is_fetch,
    input  logic                base_load,
    input  logic [VA_W-(VA_W-PAGE_BITS)-PTE_LSB-1:0] base_val,
    output logic [VA_W-1:0]     badaddr,
    output logic [VA_W-1:0]     pteaddr,
    output logic                dside
);

    localparam int VPN_W  = VA_W - PAGE_BITS;
    localparam int BASE_W = VA_W - VPN_W - PTE_LSB;
    localparam int BASE_LSB = PTE_LSB + VPN_W;

    typedef struct packed {
        logic [VA_W-1:0]   bad;
        logic [BASE_W-1:0] base;
        logic [VPN_W-1:0]  vpn;
        logic              dflag;
    } rec_t;

    rec_t st_d;
    rec_t st_q;

    always_comb begin
        st_d = st_q;
        if (rec_any) begin
            st_d.bad = vaddr;
        end
        if (rec_tlb) begin
            st_d.vpn   = vaddr[VA_W-1:PAGE_BITS];
            st_d.dflag = ~is_fetch;
        end
        if (base_load) begin
            st_d.base = base_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign badaddr = st_q.bad;
    assign pteaddr = {st_q.base, st_q.vpn, {PTE_LSB{1'b0}}};
    assign dside   = st_q.dflag;

    if (BASE_LSB + BASE_W != VA_W) begin : g_bad_layout
        initial $error("page-table-entry field layout does not fill the register");
    end

endmodule

// File: rtl/mmu_region_guard.sv
module mmu_region_guard
    import mmu_guard_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int PTE_LSB   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mmu_on,
    input  logic                        acc_valid,
    input  logic [VA_W-1:0]             acc_vaddr,
    input  logic [1:0]                  acc_kind,
    input  logic                        acc_super,
    input  logic                        lk_hit,
    input  logic [VA_W-PAGE_BITS-1:0]   lk_ppage,
    input  logic [2:0]                  lk_perm,
    input  logic                        pt_base_load,
    input  logic [VA_W-(VA_W-PAGE_BITS)-PTE_LSB-1:0] pt_base_val,
    output logic                        acc_ok,
    output logic                        acc_fault,
    output logic [2:0]                  acc_cause,
    output logic [VA_W-1:0]             acc_paddr,
    output logic [VA_W-1:0]             rec_badaddr,
    output logic [VA_W-1:0]             rec_pteaddr,
    output logic                        rec_dside,
    input  logic [VA_W-1:0]             dbg_vaddr,
    input  logic                        dbg_hit,
    input  logic [VA_W-PAGE_BITS-1:0]   dbg_ppage,
    output logic [VA_W-1:0]             dbg_paddr
);

    region_e acc_region;
    region_e dbg_region;
    cause_e  raw_cause;
    logic [VA_W-1:0] raw_paddr;
    logic    has_fault;
    logic    tlb_fault;

    mmu_region_decode #(.VA_W(VA_W)) i_acc_decode (
        .vaddr      (acc_vaddr),
        .super_mode (acc_super),
        .mmu_on     (mmu_on),
        .region     (acc_region)
    );

    mmu_perm_resolve #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) i_resolve (
        .region (acc_region),
        .vaddr  (acc_vaddr),
        .kind   (acc_kind),
        .hit    (lk_hit),
        .ppage  (lk_ppage),
        .perm   (lk_perm),
        .cause  (raw_cause),
        .paddr  (raw_paddr)
    );

    // debug path sees the supervisor view of the address space
    mmu_region_decode #(.VA_W(VA_W)) i_dbg_decode (
        .vaddr      (dbg_vaddr),
        .super_mode (1'b1),
        .mmu_on     (mmu_on),
        .region     (dbg_region)
    );

    always_comb begin
        has_fault = acc_valid && (raw_cause != CAUSE_NONE);
        tlb_fault = has_fault && (raw_cause != CAUSE_SUPER);
        acc_fault = has_fault;
        acc_ok    = acc_valid && (raw_cause == CAUSE_NONE);
        acc_cause = acc_valid ? raw_cause : CAUSE_NONE;
        acc_paddr = acc_valid ? raw_paddr : '0;

        if (dbg_region == RGN_TRANSLATE) begin
            dbg_paddr = dbg_hit ? {dbg_ppage, {PAGE_BITS{1'b0}}} : '1;
        end else begin
            dbg_paddr = {dbg_vaddr[VA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
        end
    end

    mmu_fault_regs #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PTE_LSB(PTE_LSB)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_any   (has_fault),
        .rec_tlb   (tlb_fault),
        .vaddr     (acc_vaddr),
        .is_fetch  (acc_kind[1]),
        .base_load (pt_base_load),
        .base_val  (pt_base_val),
        .badaddr   (rec_badaddr),
        .pteaddr   (rec_pteaddr),
        .dside     (rec_dside)
    );

endmodule

// File: rtl/mmu_guard_chk.sv
module mmu_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mmu_on,
    input logic        acc_valid,
    input logic [31:0] acc_vaddr,
    input logic [1:0]  acc_kind,
    input logic        acc_super,
    input logic        pt_base_load,
    input logic        acc_ok,
    input logic        acc_fault,
    input logic [2:0]  acc_cause,
    input logic [31:0] acc_paddr,
    input logic [31:0] rec_badaddr,
    input logic [31:0] rec_pteaddr,
    input logic        rec_dside
);

    // R2
    no_mmu_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !mmu_on) |-> (acc_ok && acc_paddr == acc_vaddr));

    // R7
    user_high_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && mmu_on && !acc_super && acc_vaddr[31]) |-> (acc_fault && acc_cause == 3'd5));

    // R10
    ok_fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_ok, acc_fault}));

    // R9
    bad_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |=> (rec_badaddr == $past(acc_vaddr)));

    // R9
    vpn_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fault && acc_cause != 3'd5 && !pt_base_load) |=>
        (rec_pteaddr == {$past(rec_pteaddr[31:22]), $past(acc_vaddr[31:12]), 2'b00}));

    // R8
    side_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fault && acc_cause != 3'd5) |=> (rec_dside == ($past(acc_kind[1]) == 1'b0)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_fault && !pt_base_load) |=> ($stable(rec_badaddr) && $stable(rec_pteaddr) && $stable(rec_dside)));

    // R7
    user_fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fault && acc_cause == 3'd5 && !pt_base_load) |=> ($stable(rec_pteaddr) && $stable(rec_dside)));

endmodule

bind mmu_region_guard mmu_guard_chk i_guard_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mmu_on       (mmu_on),
    .acc_valid    (acc_valid),
    .acc_vaddr    (acc_vaddr),
    .acc_kind     (acc_kind),
    .acc_super    (acc_super),
    .pt_base_load (pt_base_load),
    .acc_ok       (acc_ok),
    .acc_fault    (acc_fault),
    .acc_cause    (acc_cause),
    .acc_paddr    (acc_paddr),
    .rec_badaddr  (rec_badaddr),
    .rec_pteaddr  (rec_pteaddr),
    .rec_dside    (rec_dside)
);

// File: tb/test_mmu_region_guard.sv
module test_mmu_region_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mmu_on = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_vaddr = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_super = 1'b0;
    logic        lk_hit = 1'b0;
    logic [19:0] lk_ppage = '0;
    logic [2:0]  lk_perm = '0;
    logic        pt_base_load = 1'b0;
    logic [9:0]  pt_base_val = '0;
    logic        acc_ok;
    logic        acc_fault;
    logic [2:0]  acc_cause;
    logic [31:0] acc_paddr;
    logic [31:0] rec_badaddr;
    logic [31:0] rec_pteaddr;
    logic        rec_dside;
    logic [31:0] dbg_vaddr = '0;
    logic        dbg_hit = 1'b0;
    logic [19:0] dbg_ppage = '0;
    logic [31:0] dbg_paddr;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] m_bad = '0;
    logic [31:0] m_pte = '0;
    logic        m_d   = 1'b0;

    always #2.5 clk = ~clk;

    mmu_region_guard i_mmu_region_guard (
        .clk(clk), .rst_n(rst_n), .mmu_on(mmu_on), .acc_valid(acc_valid),
        .acc_vaddr(acc_vaddr), .acc_kind(acc_kind), .acc_super(acc_super),
        .lk_hit(lk_hit), .lk_ppage(lk_ppage), .lk_perm(lk_perm),
        .pt_base_load(pt_base_load), .pt_base_val(pt_base_val),
        .acc_ok(acc_ok), .acc_fault(acc_fault), .acc_cause(acc_cause),
        .acc_paddr(acc_paddr), .rec_badaddr(rec_badaddr), .rec_pteaddr(rec_pteaddr),
        .rec_dside(rec_dside), .dbg_vaddr(dbg_vaddr), .dbg_hit(dbg_hit),
        .dbg_ppage(dbg_ppage), .dbg_paddr(dbg_paddr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_cause(input logic [31:0] va, input logic [1:0] k,
                                             input logic sup, input logic mon,
                                             input logic hit, input logic [2:0] perm);
        logic need;
        if (!mon) return 3'd0;
        if (sup && va >= 32'hC000_0000) return 3'd0;
        if (!sup && va >= 32'h8000_0000) return 3'd5;
        if (!hit) return 3'd1;
        need = (k == 2'd0) ? perm[0] : (k == 2'd1) ? perm[1] : perm[2];
        if (!need) return (k == 2'd0) ? 3'd2 : (k == 2'd1) ? 3'd3 : 3'd4;
        return 3'd0;
    endfunction

    function automatic string req_of(input logic [31:0] va, input logic sup, input logic mon,
                                     input logic [2:0] c);
        if (!mon) return "R2";
        if (sup && va >= 32'hC000_0000) return "R3";
        if (c == 3'd5) return "R7";
        if (c == 3'd1) return "R5";
        if (c != 3'd0) return "R6";
        return "R4";
    endfunction

    function automatic logic [31:0] exp_paddr(input logic [31:0] va, input logic sup,
                                              input logic mon, input logic [19:0] pp,
                                              input logic [2:0] c);
        if (c != 3'd0) return 32'h0;
        if (!mon || (sup && va >= 32'hC000_0000)) return va;
        return {pp, va[11:0]};
    endfunction

    function automatic logic [31:0] exp_dbg(input logic [31:0] va, input logic mon,
                                            input logic hit, input logic [19:0] pp);
        if (mon && va < 32'hC000_0000) return hit ? {pp, 12'h000} : 32'hFFFF_FFFF;
        return {va[31:12], 12'h000};
    endfunction

    task automatic step(input logic v, input logic [31:0] va, input logic [1:0] k,
                        input logic sup, input logic mon, input logic hit,
                        input logic [19:0] pp, input logic [2:0] perm,
                        input logic ld, input logic [9:0] bv);
        logic [2:0] c;
        string r;
        @(negedge clk);
        acc_valid = v; acc_vaddr = va; acc_kind = k; acc_super = sup; mmu_on = mon;
        lk_hit = hit; lk_ppage = pp; lk_perm = perm; pt_base_load = ld; pt_base_val = bv;
        #1;
        c = exp_cause(va, k, sup, mon, hit, perm);
        r = req_of(va, sup, mon, c);
        if (v) begin
            chk(r, {29'd0, acc_cause}, {29'd0, c});
            chk(r, acc_paddr, exp_paddr(va, sup, mon, pp, c));
            chk("R10", {30'd0, acc_ok, acc_fault}, {30'd0, c == 3'd0, c != 3'd0});
            if (c != 3'd0) begin
                m_bad = va;
                if (c != 3'd5) begin
                    m_pte[21:0] = {va[31:12], 2'b00};
                    m_d = (k[1] == 1'b0);
                end
            end
        end else begin
            chk("R10", {30'd0, acc_ok, acc_fault}, 32'd0);
        end
        if (ld) m_pte[31:22] = bv;
        chk("R12", dbg_paddr, exp_dbg(dbg_vaddr, mon, dbg_hit, dbg_ppage));
        @(posedge clk);
        #1;
        chk((v && c == 3'd5) ? "R7" : (v && c != 3'd0) ? "R9" : "R10", rec_badaddr, m_bad);
        chk(ld ? "R11" : (v && c == 3'd5) ? "R7" : "R9", rec_pteaddr, m_pte);
        chk("R8", {31'd0, rec_dside}, {31'd0, m_d});
    endtask

    initial begin
        #(5 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        int seed_hold;
        seed_hold = $urandom(32'h5EED_0007);
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", rec_badaddr, 32'h0);
        chk("R1", rec_pteaddr, 32'h0);
        chk("R1", {31'd0, rec_dside}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R11 base load, then R5 data miss keeps base
        step(1'b0, 32'h0, 2'd0, 1'b1, 1'b1, 1'b0, 20'h0, 3'b000, 1'b1, 10'h2A5);
        step(1'b1, 32'h1234_5678, 2'd1, 1'b1, 1'b1, 1'b0, 20'h0, 3'b111, 1'b0, 10'h0);
        // R8 fetch miss clears side flag
        step(1'b1, 32'h0000_3ABC, 2'd2, 1'b0, 1'b1, 1'b0, 20'h0, 3'b111, 1'b0, 10'h0);
        // R3 boundary: supervisor just below and at bypass start, lookup misses
        step(1'b1, 32'hBFFF_FFFF, 2'd0, 1'b1, 1'b1, 1'b0, 20'h0, 3'b000, 1'b0, 10'h0);
        step(1'b1, 32'hC000_0000, 2'd0, 1'b1, 1'b1, 1'b0, 20'h0, 3'b000, 1'b0, 10'h0);
        // R7 boundary: user just below and at denied start
        step(1'b1, 32'h7FFF_F123, 2'd0, 1'b0, 1'b1, 1'b1, 20'hABCDE, 3'b001, 1'b0, 10'h0);
        step(1'b1, 32'h8000_0000, 2'd1, 1'b0, 1'b1, 1'b1, 20'hABCDE, 3'b111, 1'b0, 10'h0);
        // R6 each permission kind denied
        step(1'b1, 32'h0040_1000, 2'd0, 1'b1, 1'b1, 1'b1, 20'h11111, 3'b110, 1'b0, 10'h0);
        step(1'b1, 32'h0040_2000, 2'd1, 1'b1, 1'b1, 1'b1, 20'h11111, 3'b101, 1'b0, 10'h0);
        step(1'b1, 32'h0040_3000, 2'd3, 1'b1, 1'b1, 1'b1, 20'h11111, 3'b011, 1'b0, 10'h0);
        // R11 load together with fault
        step(1'b1, 32'h9876_5432, 2'd0, 1'b1, 1'b1, 1'b0, 20'h0, 3'b000, 1'b1, 10'h155);
        // R2 no MMU, user high address
        step(1'b1, 32'hFEED_0123, 2'd1, 1'b0, 1'b0, 1'b0, 20'h0, 3'b000, 1'b0, 10'h0);
        // R12 debug cases
        dbg_vaddr = 32'h1000_0ABC; dbg_hit = 1'b0;
        step(1'b0, 32'h0, 2'd0, 1'b0, 1'b1, 1'b0, 20'h0, 3'b000, 1'b0, 10'h0);
        dbg_hit = 1'b1; dbg_ppage = 20'h5A5A5;
        step(1'b0, 32'h0, 2'd0, 1'b0, 1'b1, 1'b0, 20'h0, 3'b000, 1'b0, 10'h0);
        dbg_vaddr = 32'hC123_4567;
        step(1'b0, 32'h0, 2'd0, 1'b0, 1'b1, 1'b0, 20'h0, 3'b000, 1'b0, 10'h0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] va;
            va = $urandom;
            dbg_vaddr = $urandom;
            dbg_hit   = ($urandom % 2) == 0;
            dbg_ppage = 20'($urandom);
            step(($urandom % 8) != 0, va, 2'($urandom % 4), 1'($urandom),
                 ($urandom % 5) != 0, ($urandom % 10) < 7, 20'($urandom),
                 3'($urandom), ($urandom % 10) == 0, 10'($urandom));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule